// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial memory with 512 bytes. A fast system clock samples the SCL and SDA lines. The block finds START and STOP conditions and decodes the device byte against two external strap pins. It pulls SDA low through an open-drain enable to acknowledge, and it runs writes and reads against an internal 512 x 8 array. A 9-bit address counter sits behind every access. Bit 8 of a memory address travels in the device byte. Bits 7:0 travel in the following word byte.

A write that stores at least one data byte raises a one-cycle request toward a separate page-write controller when the STOP arrives. While that controller reports busy, the engine does not acknowledge its device byte, so a master can poll until the write completes. A random read is a write with no data bytes, followed by a repeated START with the read bit set. No byte stream leaves the block except the serial line, so there is no valid/ready edge. The strap, busy and request pins are plain levels or pulses.

Top module: `ee_i2c_slave`

## Requirements
- R1: The device byte, sent MSB first, is type code 1010, then A2, then A1, then address bit 8, then the direction bit (1 = read, 0 = write). It is acknowledged only when the type code matches and A2/A1 equal `strap_a2`/`strap_a1`. Any other device byte gets no acknowledge, and the rest of that transaction is ignored: nothing is acknowledged and nothing is stored.
- R2: START is SDA falling while SCL is high, and it restarts address reception in any state. STOP is SDA rising while SCL is high. STOP returns the engine to idle with SDA released.
- R3: In a write, the device byte, the word byte and every data byte are acknowledged. Data bytes are stored at consecutive addresses, starting at {device-byte bit 8, word byte}.
- R4: A read sends the byte at the address counter MSB first, then advances the counter. After a write or read, the counter holds the last accessed address plus one.
- R5: A write with no data bytes, followed by a repeated START with a read device byte, returns the byte at the address it loaded.
- R6: While the master acknowledges, the engine keeps sending the following bytes. After a master no-acknowledge, it releases SDA and goes idle.
- R7: The address counter wraps from 511 to 0.
- R8: `wr_req` pulses for exactly one cycle after a STOP that ends a write in which at least one data byte was stored. It does not pulse for a write with no data bytes or for a read.
- R9: While `wr_busy` is high, a matching device byte is not acknowledged.
- R10: Incoming bits are taken on SCL rising edges. `sda_oe` changes only after an SCL falling edge, a START or a STOP, so SDA stays stable while SCL is high.
- R11: After reset, `sda_oe` is 0 and `wr_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_a2 | input | 1 | Device select strap, tie 0 if unused |
| strap_a1 | input | 1 | Device select strap, tie 0 if unused |
| wr_busy | input | 1 | Page-write controller busy |
| wr_req | output | 1 | One-cycle write-commit request |

## Verification
A table of single-byte writes, each read back with a random read, covers addresses at both ends of the array and on either side of the bit-8 boundary. This separates the path that sets bit 8 from the path that sets bits 7:0. A multi-byte write, read back sequentially, tests auto-increment across both writes and reads. A current-address read that follows it tests the "last plus one" counter value. A sequential read that starts at 511 tests the wrap. Negative patterns check that no acknowledge, no store and no commit request follow a wrong strap, a wrong type code, a busy controller or a dummy write.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADDR,
    S_WDATA,
    S_RDATA
  } ee_state_t;
endpackage

// File: rtl/ee_sync_line.sv
module ee_sync_line #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic cur,
  output logic prv
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;           // idle bus reads high
    else        sr <= {sr[STAGES-1:0], d};
  end

  assign cur = sr[STAGES-1];
  assign prv = sr[STAGES];
endmodule

// File: rtl/ee_bus_monitor.sv
module ee_bus_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_s
);
  localparam int NLINES = 2;   // index 1 = clock line, 0 = data line

  logic [NLINES-1:0] raw, cur, prv;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ee_sync_line #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .d   (raw[g]),
      .cur (cur[g]),
      .prv (prv[g])
    );
  end

  logic scl_hi_both;
  assign scl_hi_both = cur[1] & prv[1];
  assign scl_rise  =  cur[1] & ~prv[1];
  assign scl_fall  = ~cur[1] &  prv[1];
  assign start_evt = scl_hi_both &  prv[0] & ~cur[0];
  assign stop_evt  = scl_hi_both & ~prv[0] &  cur[0];
  assign sda_s     = cur[0];
endmodule

// File: rtl/ee_mem_array.sv
module ee_mem_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/ee_proto_fsm.sv
module ee_proto_fsm
  import ee_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_in,
  input  logic [1:0]    strap,
  input  logic          wr_busy,
  output logic          sda_oe,
  output logic          wr_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output ee_state_t     state_o
);
  localparam int CW = $clog2(DW + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(DW);      // count after the 8th rise
  localparam logic [CW-1:0] ACK_SLOT = CW'(DW + 1);  // count after the 9th rise
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  ee_state_t     state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic [AW-1:0] addr_q;
  logic          rw_q, mack_q, dirty_q;
  logic          dev_match;

  assign dev_match = (rx_sh[DW-1:DW-4] == DEV_TYPE) &&
                     (rx_sh[3:2] == strap) && !wr_busy;

  assign mem_addr  = addr_q;
  assign mem_wdata = rx_sh;
  assign mem_we    = (state == S_WDATA) && scl_fall && (cnt == LAST_BIT);
  assign state_o   = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      dirty_q <= 1'b0;
      sda_oe  <= 1'b0;
      wr_req  <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      if (start_evt) begin
        state  <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state  <= S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        if (dirty_q) begin
          wr_req  <= 1'b1;
          dirty_q <= 1'b0;
        end
      end else if (state != S_IDLE) begin
        if (scl_rise) begin
          if (cnt < LAST_BIT) begin
            if (state != S_RDATA) rx_sh <= {rx_sh[DW-2:0], sda_in};
            cnt <= cnt + CNT_ONE;
          end else if (cnt == LAST_BIT) begin
            mack_q <= !sda_in;
            cnt    <= cnt + CNT_ONE;
          end
        end else if (scl_fall) begin
          if (cnt == LAST_BIT) begin
            // ninth clock begins: acknowledge or release
            case (state)
              S_DEV: begin
                if (dev_match) begin
                  sda_oe <= 1'b1;
                  rw_q   <= rx_sh[0];
                  if (!rx_sh[0]) addr_q[AW-1] <= rx_sh[1];
                end else begin
                  state  <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              S_WADDR: begin
                sda_oe         <= 1'b1;
                addr_q[DW-1:0] <= rx_sh;
              end
              S_WDATA: begin
                sda_oe  <= 1'b1;
                addr_q  <= addr_q + ADDR_ONE;
                dirty_q <= 1'b1;
              end
              default: sda_oe <= 1'b0;  // read byte: master owns the ack
            endcase
          end else if (cnt == ACK_SLOT) begin
            cnt <= '0;
            case (state)
              S_DEV: begin
                if (rw_q) begin
                  state  <= S_RDATA;
                  tx_sh  <= mem_rdata;
                  sda_oe <= !mem_rdata[DW-1];
                  addr_q <= addr_q + ADDR_ONE;
                end else begin
                  state  <= S_WADDR;
                  sda_oe <= 1'b0;
                end
              end
              S_WADDR: begin
                state  <= S_WDATA;
                sda_oe <= 1'b0;
              end
              S_RDATA: begin
                if (mack_q) begin
                  tx_sh  <= mem_rdata;
                  sda_oe <= !mem_rdata[DW-1];
                  addr_q <= addr_q + ADDR_ONE;
                end else begin
                  state  <= S_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (state == S_RDATA && cnt != '0) begin
            tx_sh  <= {tx_sh[DW-2:0], 1'b0};
            sda_oe <= !tx_sh[DW-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_pkg::*;
#(
  parameter int AW          = 9,   // AW must be DW + 1: bit 8 comes from the device byte
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  input  logic strap_a2,
  input  logic strap_a1,
  input  logic wr_busy,
  output logic wr_req
);
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_s;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  ee_state_t     state;
  logic          fsm_idle;

  ee_bus_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_s    (sda_s)
  );

  ee_proto_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_in   (sda_s),
    .strap    ({strap_a2, strap_a1}),
    .wr_busy  (wr_busy),
    .sda_oe   (sda_oe),
    .wr_req   (wr_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .state_o  (state)
  );

  ee_mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (mem_addr),
    .wdata(mem_wdata),
    .rdata(mem_rdata)
  );

  assign fsm_idle = (state == S_IDLE);
endmodule

// File: rtl/ee_i2c_slave_chk.sv
module ee_i2c_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic wr_req,
  input logic scl_fall,
  input logic start_evt,
  input logic stop_evt,
  input logic in_idle
);
  // R2: STOP releases the line
  a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R2: nothing is driven while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R10: output enable moves only after a falling clock, START or STOP
  a_r10_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt));

  // R8: request is a single-cycle pulse
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R8: request only follows a STOP
  a_r8_req_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> $past(stop_evt));
endmodule

bind ee_i2c_slave ee_i2c_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .wr_req   (wr_req),
  .scl_fall (scl_fall),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .in_idle  (fsm_idle)
);

// File: tb/ee_i2c_slave_test.sv
`timescale 1ns/1ps
module ee_i2c_slave_test;
  localparam int H = 20;  // system clocks per SCL half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic wr_busy = 1'b0;
  logic sda_oe, wr_req;
  wire  sda_bus = msda & ~sda_oe;

  int errors = 0, checks = 0, reqs = 0, glitches = 0;

  always #5 clk = ~clk;

  ee_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_a2(1'b1), .strap_a1(1'b0), .wr_busy(wr_busy), .wr_req(wr_req)
  );

  always @(posedge clk) if (wr_req) reqs++;

  // {addr[8:0], data[7:0]}
  localparam logic [16:0] VEC [6] = '{
    {9'h000, 8'h3C}, {9'h0FF, 8'hA1}, {9'h100, 8'h5E},
    {9'h1FF, 8'hC7}, {9'h0A5, 8'h00}, {9'h155, 8'hFF}
  };

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    msda = 1'b1; w(H); scl = 1'b1; w(H); msda = 1'b0; w(H); scl = 1'b0; w(H);
  endtask

  task automatic bus_stop();
    msda = 1'b0; w(H); scl = 1'b1; w(H); msda = 1'b1; w(H);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; w(H); scl = 1'b1; w(H); scl = 1'b0;
    end
    msda = 1'b1; w(H); scl = 1'b1; w(H/2); ack = !sda_bus; w(H/2); scl = 1'b0;
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    logic early;
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl = 1'b1; w(2); early = sda_bus; w(H/2 - 2); b[i] = sda_bus;
      w(H/2 - 1); if (sda_bus !== early) glitches++; w(1); scl = 1'b0;
    end
    msda = !mack; w(H); scl = 1'b1; w(H); scl = 1'b0; w(1); msda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic b8, input logic rd);
    return {4'b1010, 1'b1, 1'b0, b8, rd};
  endfunction

  task automatic set_addr(input logic [8:0] a, input string tag);
    logic ack;
    bus_start(); send(dev(a[8], 1'b0), ack); chk({tag, " dev ack"}, ack, 1);
    send(a[7:0], ack); chk({tag, " word ack"}, ack, 1);
  endtask

  task automatic read_at(input logic [8:0] a, output logic [7:0] d);
    logic ack;
    set_addr(a, "R5 dummy write");
    bus_start(); send(dev(a[8], 1'b1), ack); chk("R5 read dev ack", ack, 1);
    recv(1'b0, d); bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] d;
    int r0;
    w(5);
    chk("R11 sda_oe at reset", sda_oe, 0);
    chk("R11 wr_req at reset", wr_req, 0);
    rst_n = 1'b1; w(5);
    chk("R11 sda_oe after reset", sda_oe, 0);

    // table walk: byte write then random read
    foreach (VEC[k]) begin
      r0 = reqs;
      set_addr(VEC[k][16:8], "R3 byte write");
      send(VEC[k][7:0], ack); chk("R3 data ack", ack, 1);
      bus_stop(); w(4);
      chk("R8 one request per write", reqs - r0, 1);
      chk("R2 released after stop", sda_oe, 0);
      r0 = reqs;
      read_at(VEC[k][16:8], d);
      chk("R5 random read data", d, VEC[k][7:0]);
      chk("R8 no request for dummy write/read", reqs - r0, 0);
    end

    // multi-byte write, sequential read, current-address read
    r0 = reqs;
    set_addr(9'h010, "R3 page write");
    for (int i = 0; i < 4; i++) begin
      send(8'h90 + 8'(i), ack); chk("R3 page data ack", ack, 1);
    end
    bus_stop(); w(4);
    chk("R8 single request for page", reqs - r0, 1);
    set_addr(9'h010, "R6 seq read");
    bus_start(); send(dev(1'b0, 1'b1), ack); chk("R6 read dev ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv(i != 3, d); chk("R6 sequential data", d, 8'h90 + 8'(i));
    end
    w(4); chk("R6 released after master nack", sda_oe, 0);
    bus_stop();
    read_at(9'h011, d);
    bus_start(); send(dev(1'b0, 1'b1), ack); chk("R4 current read ack", ack, 1);
    recv(1'b0, d); bus_stop();
    chk("R4 current read returns last+1", d, 8'h92);

    // wrap 511 -> 0 (table stored C7 at 1FF, 3C at 000)
    set_addr(9'h1FF, "R7 wrap");
    bus_start(); send(dev(1'b1, 1'b1), ack);
    recv(1'b1, d); chk("R7 byte at 511", d, 8'hC7);
    recv(1'b0, d); chk("R7 wrapped byte at 0", d, 8'h3C);
    bus_stop();

    // strap mismatch: no ack, nothing stored, no request
    r0 = reqs;
    bus_start(); send(8'b1010_0100, ack); chk("R1 wrong strap nack", ack, 0);
    send(8'h00, ack); chk("R1 ignored word byte", ack, 0);
    send(8'h77, ack); chk("R1 ignored data byte", ack, 0);
    bus_stop(); w(4);
    chk("R1 no request after ignored write", reqs - r0, 0);
    read_at(9'h000, d); chk("R1 memory unchanged", d, 8'h3C);
    bus_start(); send(8'b1011_1000, ack); chk("R1 wrong type code nack", ack, 0);
    bus_stop();

    // busy controller
    wr_busy = 1'b1;
    bus_start(); send(dev(1'b0, 1'b0), ack); chk("R9 busy nack", ack, 0);
    bus_stop();
    wr_busy = 1'b0;
    bus_start(); send(dev(1'b0, 1'b0), ack); chk("R9 ack after busy clears", ack, 1);
    // R2: repeated START mid word byte restarts address reception
    msda = 1'b0; w(H); scl = 1'b1; w(H); scl = 1'b0;
    bus_start(); send(dev(1'b0, 1'b0), ack); chk("R2 ack after restart", ack, 1);
    bus_stop(); w(4);
    chk("R2 idle after stop", sda_oe, 0);

    chk("R10 read data stable while SCL high", glitches, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule